// File: doc/BRIEF.md
# Bus Reset and Line Activity Detector

This block watches one of two serial line conditions and raises a single interrupt request when that condition has persisted long enough. A mode input selects the condition. In USB mode the block looks for a single-ended zero (SE0), where both differential data lines sit low. In PS/2 mode it looks for a sustained low on the serial data line. The same qualification hardware serves both modes, but each mode fires at a different point in the event.

Qualification is coarse by design. A free-running divider produces one tick per 128 µs of core clock, which is 1536 cycles at 12 MHz. A small saturating counter counts the ticks seen while the condition holds. The counter clears whenever the condition is absent or the mode changes. The condition is qualified once the counter reaches `QUAL_TICKS` ticks, which is two by default. A condition that lasts less than one tick period never fires. A condition that lasts two full tick periods always fires.

In USB mode the interrupt fires at the moment a qualified SE0 ends. In PS/2 mode it fires as soon as qualification is reached, while the line is still low. Each event produces a one-cycle pulse and sets a sticky pending flag, which software-side logic clears through a clear input.

Top module: `bus_act_det`

## Requirements
- R1: After reset is released, `irq_o` and `pend_o` are both 0.
- R2: In USB mode (`mode_i`=0), only both `dp_i` and `dm_i` low counts as the condition, and `sdata_i` has no effect. In PS/2 mode (`mode_i`=1), only `sdata_i` low counts, and `dp_i`/`dm_i` have no effect.
- R3: A condition that lasts at most `TICK_CYC` cycles never produces a pulse.
- R4: A condition that lasts at least 2×`TICK_CYC` cycles always produces exactly one pulse.
- R5: In USB mode, the pulse appears on the clock edge exactly 3 cycles after the lines leave SE0. This delay is two synchronizer stages plus the output register. No pulse appears while SE0 is still held.
- R6: In PS/2 mode, the pulse appears while the line is still low. It comes no earlier than `TICK_CYC`+3 cycles after the line falls and no later than 2 cycles after it is released.
- R7: `irq_o` is high for exactly one cycle per event. Holding the condition longer produces no further pulse.
- R8: `pend_o` rises together with `irq_o` and holds until `clr_i` is high at a clock edge. If a new pulse coincides with `clr_i`, the set wins.
- R9: A change of `mode_i` discards any qualification in progress. A qualified SE0 that ends after a switch to PS/2 mode produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = USB bus reset, 1 = PS/2 activity |
| dp_i | input | 1 | USB D+ line, asynchronous |
| dm_i | input | 1 | USB D- line, asynchronous |
| sdata_i | input | 1 | PS/2 serial data line, asynchronous |
| clr_i | input | 1 | Clears the pending flag |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pend_o | output | 1 | Sticky pending flag |

## Verification
The assertions assume that `mode_i` changes only when no event is being qualified or is in flight. They also assume that line inputs, once synchronized, are clean levels, so an event's duration is simply the number of cycles the synchronized condition is true.

The stimulus drives every line change and mode change on the falling clock edge. It leaves several idle cycles between events, so the counter is back at zero before the next condition begins. It sweeps the condition length from one cycle to three tick periods. It shifts the starting tick phase with each length, so that both edges of the 128–256 µs window are reached from many alignments.

// File: rtl/lde_pkg.sv
package lde_pkg;
  typedef enum logic {
    MODE_USB = 1'b0,
    MODE_PS2 = 1'b1
  } det_mode_e;
endpackage

// File: rtl/lde_sync.sv
module lde_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= rst_val_i;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lde_tick.sv
module lde_tick #(
  parameter int TICK_CYC = 1536
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int DW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_CYC - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/lde_qual.sv
module lde_qual #(
  parameter int QUAL_TICKS = 2,
  localparam int CW = $clog2(QUAL_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          cond_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          qual_o,
  output logic          rise_o
);
  localparam logic [CW-1:0] FULL = CW'(QUAL_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (flush_i || !cond_i) cnt_q <= '0;
    else if (tick_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign qual_o = (cnt_q == FULL);
  // counter about to saturate: qualification reached on this edge
  assign rise_o = tick_i && cond_i && !flush_i && (cnt_q == FULL - 1'b1);
endmodule

// File: rtl/bus_act_det.sv
module bus_act_det
  import lde_pkg::*;
#(
  parameter int TICK_CYC   = 1536,
  parameter int QUAL_TICKS = 2,
  localparam int CW = $clog2(QUAL_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic dp_i,
  input  logic dm_i,
  input  logic sdata_i,
  input  logic clr_i,
  output logic irq_o,
  output logic pend_o
);
  logic [2:0]    line_s;
  logic          tick;
  logic          cond;
  logic          mode_chg;
  logic          qual;
  logic          rise;
  logic          fire;
  logic [CW-1:0] cnt;
  det_mode_e     mode_q;
  logic          irq_q, pend_q;

  lde_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       ({sdata_i, dm_i, dp_i}),
    .rst_val_i (3'b111),
    .q_o       (line_s)
  );

  lde_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_USB;
    else         mode_q <= det_mode_e'(mode_i);
  end

  assign mode_chg = (mode_i != mode_q);
  assign cond = (mode_q == MODE_PS2) ? !line_s[2] : (!line_s[0] && !line_s[1]);

  lde_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (mode_chg),
    .cond_i  (cond),
    .tick_i  (tick),
    .cnt_o   (cnt),
    .qual_o  (qual),
    .rise_o  (rise)
  );

  // PS/2 fires on qualification; USB fires when a qualified SE0 ends
  assign fire = (mode_q == MODE_PS2) ? rise : (qual && !cond && !mode_chg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      irq_q  <= fire;
      pend_q <= fire || (pend_q && !clr_i);
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/lde_checker.sv
module lde_checker #(
  parameter int QUAL_TICKS = 2,
  localparam int CW = $clog2(QUAL_TICKS + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          irq_o,
  input logic          pend_o,
  input logic          cond_i,
  input logic          mode_q_i,
  input logic          mode_chg_i,
  input logic [CW-1:0] cnt_i
);
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_pend_on_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o);
  p_pend_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pend_o == irq_o));
  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(QUAL_TICKS));
  p_drop_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> (cnt_i == '0));
  p_mode_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_i |=> (cnt_i == '0 && !irq_o));
  p_usb_at_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(mode_q_i)) |-> !$past(cond_i));
  p_ps2_while_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(mode_q_i)) |-> $past(cond_i));
endmodule

bind bus_act_det lde_checker #(.QUAL_TICKS(QUAL_TICKS)) u_lde_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .irq_o      (irq_o),
  .pend_o     (pend_o),
  .cond_i     (cond),
  .mode_q_i   (mode_q),
  .mode_chg_i (mode_chg),
  .cnt_i      (cnt)
);

// File: tb/bus_act_det_bench.sv
module bus_act_det_bench;
  localparam int CLK_PER = 10;
  localparam int DIV     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, dp = 1'b1, dm = 1'b1, sd = 1'b1, clr = 1'b0;
  logic irq, pend;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  bus_act_det #(.TICK_CYC(DIV), .QUAL_TICKS(2)) u_bus_act_det (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dp_i(dp), .dm_i(dm),
    .sdata_i(sd), .clr_i(clr), .irq_o(irq), .pend_o(pend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold the given line pattern for len cycles, then idle; count pulses
  task automatic run_ev(input logic p_dp, input logic p_dm, input logic p_sd,
                        input int len, input bit hold_clr,
                        output int n, output int at, output bit pend_bad);
    n = 0; at = -1; pend_bad = 0;
    dp = p_dp; dm = p_dm; sd = p_sd; clr = hold_clr;
    for (int m = 1; m <= len + 8; m++) begin
      @(negedge clk);
      if (irq) begin n++; at = m; if (!pend) pend_bad = 1; end
      else if (hold_clr && pend) pend_bad = 1;
      if (m == len) begin dp = 1'b1; dm = 1'b1; sd = 1'b1; end
    end
    clr = 1'b0;
  endtask

  task automatic set_mode(input logic md);
    mode = md;
    idle(4);
  endtask

  initial begin
    int n, at;
    bit pb;
    idle(3);
    chk(irq == 0, "R1 irq in reset", irq, 0);
    chk(pend == 0, "R1 pend in reset", pend, 0);
    rst_n = 1'b1;
    idle(2);
    chk(irq == 0, "R1 irq after reset", irq, 0);
    chk(pend == 0, "R1 pend after reset", pend, 0);

    // length/phase sweep, both modes
    for (int md = 0; md < 2; md++) begin
      set_mode(md[0]);
      for (int len = 1; len <= 3*DIV; len++) begin
        idle(3 + (len * 3) % DIV);
        if (md == 0) run_ev(1'b0, 1'b0, 1'b1, len, 1'b0, n, at, pb);
        else         run_ev(1'b1, 1'b1, 1'b0, len, 1'b0, n, at, pb);
        if (len <= DIV) chk(n == 0, "R3 short condition", n, 0);
        else if (len >= 2*DIV) chk(n == 1, "R4 long condition", n, 1);
        else chk(n <= 1, "R7 at most one pulse", n, 1);
        if (n == 1 && md == 0) chk(at == len + 3, "R5 usb pulse timing", at, len + 3);
        if (n == 1 && md == 1)
          chk(at >= DIV + 3 && at <= len + 2, "R6 ps2 pulse timing", at, len + 2);
        chk(pend == (n > 0), "R8 pend follows event", pend, n > 0);
        chk(!pb, "R8 pend with irq", pb, 0);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk(pend == 0, "R8 pend cleared", pend, 0);
      end
    end

    // R2 wrong-line patterns
    set_mode(1'b0);
    run_ev(1'b0, 1'b1, 1'b1, 3*DIV, 1'b0, n, at, pb);
    chk(n == 0, "R2 usb dp low only", n, 0);
    run_ev(1'b1, 1'b0, 1'b1, 3*DIV, 1'b0, n, at, pb);
    chk(n == 0, "R2 usb dm low only", n, 0);
    run_ev(1'b1, 1'b1, 1'b0, 3*DIV, 1'b0, n, at, pb);
    chk(n == 0, "R2 usb ignores sdata", n, 0);
    set_mode(1'b1);
    run_ev(1'b0, 1'b0, 1'b1, 3*DIV, 1'b0, n, at, pb);
    chk(n == 0, "R2 ps2 ignores se0", n, 0);

    // R7 very long hold in both modes
    run_ev(1'b1, 1'b1, 1'b0, 6*DIV, 1'b0, n, at, pb);
    chk(n == 1, "R7 ps2 long hold single pulse", n, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    set_mode(1'b0);
    run_ev(1'b0, 1'b0, 1'b1, 6*DIV, 1'b0, n, at, pb);
    chk(n == 1, "R7 usb long hold single pulse", n, 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;

    // R8 set wins over a held clear
    run_ev(1'b0, 1'b0, 1'b1, 3*DIV, 1'b1, n, at, pb);
    chk(n == 1, "R8 event under clear", n, 1);
    chk(!pb, "R8 set wins, then clears", pb, 0);
    chk(pend == 0, "R8 pend low after clear", pend, 0);

    // R9 mode switch drops a qualified SE0
    idle(3);
    dp = 1'b0; dm = 1'b0;
    n = 0;
    for (int m = 0; m < 3*DIV; m++) begin @(negedge clk); if (irq) n++; end
    mode = 1'b1;
    idle(2);
    dp = 1'b1; dm = 1'b1;
    for (int m = 0; m < 10; m++) begin @(negedge clk); if (irq) n++; end
    chk(n == 0, "R9 mode switch discards", n, 0);
    chk(pend == 0, "R9 no pending", pend, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PER * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule